// File: doc/BRIEF.md
# Line-Service Detection Status Latch

This block gathers the outcome of vertical-blanking line decoding for four services: wide screen signalling, closed captioning, an extended-definition sequence and copy-generation management. An upstream slicer reports one result per decoded packet, along with the packet's start-edge window and integrity checks, and writes the decoded payload bytes one at a time. For each service the block qualifies a confidence flag under that service's own rule. It collects the flags and payload bytes in shadow registers while a field is in progress.

On each rising edge of the synchronised field signal, the whole shadow set is copied into host-visible registers. The host registers then stay frozen for the rest of the field, so a host can read the status byte first and then the matching data bytes without getting a mix of two fields. The only writable item is one control bit. It chooses between CRC-based and window-only qualification for the copy-management service. All decode status and data registers are read-only.

Top module: `vbi_status_latch`

## Requirements
- R1: The status byte at read address 0 holds the wide-screen flag in bit 0, closed caption in bit 1, extended-definition in bit 2 and copy-management in bit 3. Bits 7 to 4 always read 0. The result input `res_svc` uses the same codes: 0 wide-screen, 1 closed caption, 2 extended-definition, 3 copy-management.
- R2: For services 0, 1 and 2, a result sets the shadow flag only when both `res_win_ok` and `res_par_ok` are 1.
- R3: With CRC checking on, a copy-management result sets its shadow flag exactly when `res_crc_ok` is 1.
- R4: With CRC checking off, a copy-management result sets its shadow flag exactly when `res_win_ok` is 1.
- R5: The CRC-check enable resets to 1. A cycle with `crc_en_we` high loads `crc_en_wd` into it. It reads back in bit 0 of address 11, with the other bits 0.
- R6: `field_in` passes through a two-flop synchroniser. The host registers take the shadow contents at the third rising clock edge after `field_in` rises, counting the first edge that samples it high. Before that edge the host registers show the previous field's values.
- R7: Between transfers, the host registers stay constant whatever results, byte writes or control writes arrive.
- R8: Payload bytes are loaded from `byte_val` into shadow entry `byte_idx` (0 to 9) whether or not the matching flag is set. An entry keeps its value across fields until it is rewritten. Indices 10 to 15 are ignored.
- R9: The shadow flags clear in the transfer cycle. A service not seen during a field reports 0 after the next transfer.
- R10: Read addresses 1 to 10 return payload entries 0 to 9: wide-screen 1–2, closed caption 3–4, extended-definition 5–7, copy-management 8–10. Addresses 12 to 15 return 0x00.
- R11: After reset, every status and data address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_in | input | 1 | Asynchronous field signal; rising edge triggers transfer |
| res_vld | input | 1 | One decoded packet result this cycle |
| res_svc | input | 2 | Service code of the result |
| res_win_ok | input | 1 | Start-bit rising edge fell inside the window |
| res_par_ok | input | 1 | Parity bit agrees with the data |
| res_crc_ok | input | 1 | Computed CRC checksum is valid |
| byte_we | input | 1 | Write one payload byte to the shadow set |
| byte_idx | input | 4 | Payload entry index |
| byte_val | input | 8 | Payload byte value |
| crc_en_we | input | 1 | Write the CRC-check enable |
| crc_en_wd | input | 1 | New CRC-check enable value |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 8 | Host read data (combinational) |

## Verification
The hardest situation to reach is when new results and byte writes arrive after a transfer while the host registers must still show the field just closed. This is the point where a design that copies live shadow data would leak the next field. The stimulus runs many short fields of random results and byte writes. It reads every address between two synchroniser edges, just before the transfer lands, and again once new shadow traffic has started. Directed fields cover a field with no results, CRC bypass with a bad checksum, and data written under a failed flag.

// File: rtl/vbi_status_latch.sv
module vbi_status_latch #(
  parameter int NB = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       field_in,
  input  logic       res_vld,
  input  logic [1:0] res_svc,
  input  logic       res_win_ok,
  input  logic       res_par_ok,
  input  logic       res_crc_ok,
  input  logic       byte_we,
  input  logic [3:0] byte_idx,
  input  logic [7:0] byte_val,
  input  logic       crc_en_we,
  input  logic       crc_en_wd,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam logic [3:0] CTL_ADDR = 4'(NB + 1);

  logic [2:0]           fsync;
  logic                 xfer;
  logic                 crc_en;
  logic                 hit;
  logic [3:0]           sh_flag, hs_flag;
  logic [NB-1:0][7:0]   sh_byte, hs_byte;

  assign xfer = fsync[1] & ~fsync[2];

  always_comb begin
    hit = 1'b0;
    if (res_vld) begin
      if (res_svc == 2'd3) hit = crc_en ? res_crc_ok : res_win_ok;
      else                 hit = res_win_ok & res_par_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsync   <= '0;
      crc_en  <= 1'b1;
      sh_flag <= '0;
      hs_flag <= '0;
      sh_byte <= '0;
      hs_byte <= '0;
    end else begin
      fsync <= {fsync[1:0], field_in};
      if (crc_en_we) crc_en <= crc_en_wd;
      sh_flag <= (xfer ? 4'b0 : sh_flag) | (hit ? 4'(1 << res_svc) : 4'b0);
      if (xfer) begin
        hs_flag <= sh_flag;
        hs_byte <= sh_byte;
      end
      if (byte_we && byte_idx < 4'(NB)) sh_byte[byte_idx] <= byte_val;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == 4'd0)                          rd_data = {4'b0, hs_flag};
    else if (rd_addr <= 4'(NB))                   rd_data = hs_byte[rd_addr - 4'd1];
    else if (rd_addr == CTL_ADDR)                 rd_data = {7'b0, crc_en};
  end

  // R7
  host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(hs_flag) && $stable(hs_byte)));

  // R6
  host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (hs_flag == $past(sh_flag) && hs_byte == $past(sh_byte)));

  // R2
  par_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_svc != 2'd3 && !(res_win_ok && res_par_ok) && !xfer)
      |=> sh_flag[$past(res_svc)] == $past(sh_flag[res_svc]));

  // R3
  crc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_svc == 2'd3 && crc_en && !res_crc_ok && !sh_flag[3] && !xfer)
      |=> !sh_flag[3]);

  // R9
  field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !res_vld) |=> sh_flag == 4'b0);

  // R1
  status_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 4'd0 |-> rd_data[7:4] == 4'b0);
endmodule

// File: tb/sim_vbi_status_latch.sv
module sim_vbi_status_latch;
  logic clk = 0, rst_n = 0, field_in = 0;
  logic res_vld = 0, res_win_ok = 0, res_par_ok = 0, res_crc_ok = 0;
  logic [1:0] res_svc = 0;
  logic byte_we = 0, crc_en_we = 0, crc_en_wd = 0;
  logic [3:0] byte_idx = 0, rd_addr = 0;
  logic [7:0] byte_val = 0, rd_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic       m_crc;
  logic [3:0] m_shf, m_hsf;
  logic [7:0] m_shb [10];
  logic [7:0] m_hsb [10];

  always #4 clk = ~clk;

  vbi_status_latch u0 (.*);

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a == 0) return {4'b0, m_hsf};
    if (a <= 10) return m_hsb[a-1];
    if (a == 11) return {7'b0, m_crc};
    return 8'h00;
  endfunction

  function automatic logic rule(input logic [1:0] s, input logic w, p, c, en);
    if (s == 3) return en ? c : w;
    return w & p;
  endfunction

  task automatic check(input string req, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #1;
      check(req, rd_data, exp_rd(4'(a)));
    end
  endtask

  task automatic send(input logic [1:0] s, input logic w, p, c);
    @(negedge clk);
    res_vld = 1; res_svc = s; res_win_ok = w; res_par_ok = p; res_crc_ok = c;
    if (rule(s, w, p, c, m_crc)) m_shf[s] = 1'b1;
    @(negedge clk);
    res_vld = 0;
  endtask

  task automatic wbyte(input logic [3:0] i, input logic [7:0] v);
    @(negedge clk);
    byte_we = 1; byte_idx = i; byte_val = v;
    if (i < 10) m_shb[i] = v;
    @(negedge clk);
    byte_we = 0;
  endtask

  task automatic wcrc(input logic v);
    @(negedge clk);
    crc_en_we = 1; crc_en_wd = v;
    @(negedge clk);
    crc_en_we = 0; m_crc = v;
  endtask

  task automatic transfer(input string req);
    @(negedge clk);
    field_in = 1;
    repeat (2) @(negedge clk);
    rd_addr = 0; #1;
    check("R6 pre", rd_data, {4'b0, m_hsf});
    @(negedge clk);
    m_hsf = m_shf; m_shf = 0;
    for (int i = 0; i < 10; i++) m_hsb[i] = m_shb[i];
    read_all(req);
    field_in = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog act=00 exp=01");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7151));
    m_crc = 1; m_shf = 0; m_hsf = 0;
    for (int i = 0; i < 10; i++) begin m_shb[i] = 0; m_hsb[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    read_all("R11 R5 reset");

    // R2: one good and two bad results, R8 data under a failed flag
    send(0, 1, 1, 0);
    send(1, 1, 0, 1);
    send(2, 0, 1, 1);
    wbyte(2, 8'hA5);
    wbyte(12, 8'h77);
    send(3, 0, 0, 1);
    transfer("R2 R3 R8 R1");

    // R7: new traffic after transfer leaves host frozen
    send(1, 1, 1, 0);
    wbyte(0, 8'h3C);
    wcrc(0);
    for (int a = 0; a < 11; a++) begin
      rd_addr = 4'(a); #1;
      check("R7 hold", rd_data, exp_rd(4'(a)));
    end
    transfer("R6 R10 R5");

    // R9: empty field clears flags
    transfer("R9 empty");

    // R4: bypass, bad crc with good window
    send(3, 1, 0, 0);
    send(2, 0, 0, 1);
    transfer("R4 bypass");
    wcrc(1);
    send(3, 1, 1, 0);
    transfer("R3 crc bad");

    for (int f = 0; f < 40; f++) begin
      int n = int'($urandom_range(1, 8));
      for (int k = 0; k < n; k++) begin
        case ($urandom_range(0, 2))
          0: send(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
          1: wbyte(4'($urandom), 8'($urandom));
          default: if ($urandom_range(0, 3) == 0) wcrc(1'($urandom));
        endcase
      end
      transfer("R1 R2 R3 R4 R8 R10 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule